// File: doc/BRIEF.md
# Camp-On Multicast Connection Arbiter

This block sits on the switch side of a crossbar fabric. Each input port delivers connection request words. A request names a bitmap of the output ports it wants. The arbiter stores the latest request of every input and re-arbitrates it on every cycle until each wanted output has been granted. The input can also drop the request by sending an idle word, or replace it with a new request. A granted output stays tied to its input until that input sends a request word with the break flag set.

A request stored with the early flag outranks every other contender for an output. Among ordinary requests, a round-robin pointer per output picks the winner. An output flagged out of sync grants every contender at once and never asserts backpressure. When a request's last missing output is granted, the arbiter sends a one-cycle acknowledge back to that input.

The request word interface has a valid strobe only. The arbiter accepts every word in the cycle it is presented, so no ready signal exists and no back-pressure acts on request words. The only flow-control output is the per-output backpressure level.

Top module: `camp_arbiter`

## Requirements
- R1: After reset, every acknowledge and every backpressure output is low, no request is stored, and every output is free.
- R2: A word with valid high and kind 1 is a request and replaces the stored request of that input. A word with kind 0 is idle and discards the stored request, which is then never acknowledged. An input takes no part in arbitration in a cycle in which it presents a word.
- R3: The acknowledge of an input is a pulse that lasts exactly one cycle. It rises one cycle after the clock edge at which the last missing output of its request was granted. A request whose outputs are all free is sampled at edge k and acknowledged in the cycle after edge k+1.
- R4: A multicast request is not acknowledged while any of its wanted outputs is still ungranted. Outputs already granted to it remain held by that input.
- R5: An ungranted request stays stored and competes on every cycle. It wins as soon as its outputs become available.
- R6: For one output, a stored request carrying the early flag wins over every request without it, whatever the round-robin pointer says.
- R7: Among requests without the early flag, an output picks the first requesting input after the last input it granted, in ascending index order with wrap-around. After reset the search starts at input 0.
- R8: A granted output stays owned by its input until that input presents a request word with the break flag set. The output is released at that edge, and other inputs may win it at the next edge. While an output is owned, at most one input is granted it.
- R9: An input that requests an output it already owns is granted that output at once.
- R10: An out-of-sync output grants every input that wants it in the same cycle. It takes no new owner while out of sync.
- R11: The backpressure output of port o equals the full input of port o AND NOT its out-of-sync flag, one cycle later.
- R12: A replaced request is dropped without acknowledge, even if its outputs later become free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | N_IN | A control word from input i is present this cycle |
| word_kind | input | N_IN | 1 = request word, 0 = idle word |
| word_early | input | N_IN | Request carries early camp-on priority |
| word_brk | input | N_IN | Request word releases every output owned by that input |
| word_mask | input | N_IN*N_OUT | Wanted outputs; bits [i*N_OUT +: N_OUT] belong to input i |
| out_oos | input | N_OUT | Output link is out of sync |
| out_full | input | N_OUT | Output side asks for flow control |
| ack | output | N_IN | One-cycle grant-complete pulse per input |
| bp | output | N_OUT | Backpressure per output |

## Verification
A request word sampled at edge k enters the store at that edge. The earliest grant comes at edge k+1, so a free-output acknowledge is due in the cycle after edge k+1. A release caused by a break word adds one more edge before a waiting input can win. Backpressure follows full and out-of-sync one edge later. The bench drives inputs and samples outputs at the falling edge, and a bench model advances at the same rising edges, so each expected acknowledge and backpressure value is compared in the exact cycle it is due.

// File: rtl/camp_pkg.sv
package camp_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_REQ  = 1'b1
  } word_kind_e;
endpackage

// File: rtl/camp_req_slot.sv
module camp_req_slot
  import camp_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_kind,
  input  logic [N_OUT-1:0] wr_mask,
  input  logic             wr_early,
  input  logic [N_OUT-1:0] grant_row,
  output logic             pend,
  output logic [N_OUT-1:0] want,
  output logic             early,
  output logic             ack
);
  logic             pend_q, early_q, ack_q;
  logic [N_OUT-1:0] want_q, left;

  assign left = want_q & ~grant_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      early_q <= 1'b0;
      want_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (wr_valid) begin
        if (wr_kind == WK_REQ) begin
          pend_q  <= 1'b1;
          want_q  <= wr_mask;
          early_q <= wr_early;
        end else begin
          pend_q  <= 1'b0;
          want_q  <= '0;
          early_q <= 1'b0;
        end
      end else if (pend_q) begin
        want_q <= left;
        if (left == '0) begin
          pend_q  <= 1'b0;
          early_q <= 1'b0;
          ack_q   <= 1'b1;
        end
      end
    end
  end

  assign pend  = pend_q;
  assign want  = want_q;
  assign early = early_q;
  assign ack   = ack_q;

  a_r3_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !pend_q);
  a_r2_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_kind == WK_IDLE) |=> !pend_q && !ack_q);
  a_r5_camped_stays: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !wr_valid && (left != '0) |=> pend_q);
  a_r4_no_partial_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !wr_valid && (left != '0) |=> !ack_q);
endmodule

// File: rtl/camp_out_arb.sv
module camp_out_arb #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] cand,
  input  logic [N_IN-1:0] early,
  input  logic [N_IN-1:0] release_req,
  input  logic            oos,
  input  logic            full,
  output logic [N_IN-1:0] grant,
  output logic            bp
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic            owned_q, owned_d;
  logic [IW-1:0]   owner_q, owner_d, rr_q, rr_d, win;
  logic [N_IN-1:0] allowed, contend, pool, pick;
  logic            bp_q;

  function automatic logic [N_IN-1:0] rr_pick(input logic [N_IN-1:0] req,
                                              input logic [IW-1:0] ptr);
    logic [N_IN-1:0] res;
    logic            found;
    res   = '0;
    found = 1'b0;
    for (int k = 1; k <= N_IN; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N_IN;
      if (req[idx] && !found) begin
        res[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    allowed = owned_q ? (N_IN'(1) << owner_q) : '1;
    contend = cand & allowed;
    pool    = ((contend & early) != '0) ? (contend & early) : contend;
    pick    = rr_pick(pool, rr_q);
    grant   = oos ? cand : pick;
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < N_IN; i++)
      if (pick[i]) win = IW'(i);
  end

  always_comb begin
    owned_d = owned_q;
    owner_d = owner_q;
    rr_d    = rr_q;
    if (owned_q && release_req[owner_q]) owned_d = 1'b0;
    if (!oos && (pick != '0)) begin
      owned_d = 1'b1;
      owner_d = win;
      rr_d    = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      rr_q    <= IW'(N_IN - 1);
      bp_q    <= 1'b0;
    end else begin
      owned_q <= owned_d;
      owner_q <= owner_d;
      rr_q    <= rr_d;
      bp_q    <= full & ~oos;
    end
  end

  assign bp = bp_q;

  a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !oos |-> $onehot0(grant));
  a_r8_hold_until_break: assert property (@(posedge clk) disable iff (!rst_n)
    owned_q && !release_req[owner_q] |=> owned_q && $stable(owner_q));
  a_r6_early_first: assert property (@(posedge clk) disable iff (!rst_n)
    !oos && ((cand & allowed & early) != '0) |-> ((grant & early) != '0));
  a_r10_no_new_owner: assert property (@(posedge clk) disable iff (!rst_n)
    oos && !owned_q |=> !owned_q);
  a_r11_oos_no_bp: assert property (@(posedge clk) disable iff (!rst_n)
    oos |=> !bp_q);
  a_r2_grant_only_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~cand) == '0);
endmodule

// File: rtl/camp_arbiter.sv
module camp_arbiter #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       word_valid,
  input  logic [N_IN-1:0]       word_kind,
  input  logic [N_IN-1:0]       word_early,
  input  logic [N_IN-1:0]       word_brk,
  input  logic [N_IN*N_OUT-1:0] word_mask,
  input  logic [N_OUT-1:0]      out_oos,
  input  logic [N_OUT-1:0]      out_full,
  output logic [N_IN-1:0]       ack,
  output logic [N_OUT-1:0]      bp
);
  logic [N_IN-1:0]  pend, early, release_req;
  logic [N_OUT-1:0] want_i  [N_IN];
  logic [N_OUT-1:0] grant_i [N_IN];
  logic [N_IN-1:0]  cand_o  [N_OUT];
  logic [N_IN-1:0]  grant_o [N_OUT];

  assign release_req = word_valid & word_kind & word_brk;

  always_comb begin
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++) begin
        cand_o[o][i]  = pend[i] & want_i[i][o] & ~word_valid[i];
        grant_i[i][o] = grant_o[o][i];
      end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_slot
    camp_req_slot #(.N_OUT(N_OUT)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (word_valid[i]),
      .wr_kind   (word_kind[i]),
      .wr_mask   (word_mask[i*N_OUT +: N_OUT]),
      .wr_early  (word_early[i]),
      .grant_row (grant_i[i]),
      .pend      (pend[i]),
      .want      (want_i[i]),
      .early     (early[i]),
      .ack       (ack[i])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    camp_out_arb #(.N_IN(N_IN)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .cand        (cand_o[o]),
      .early       (early),
      .release_req (release_req),
      .oos         (out_oos[o]),
      .full        (out_full[o]),
      .grant       (grant_o[o]),
      .bp          (bp[o])
    );
  end
endmodule

// File: tb/tb_camp_arbiter.sv
module tb_camp_arbiter;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0]       wv = '0, wk = '0, we = '0, wb = '0;
  logic [N_IN*N_OUT-1:0] wm = '0;
  logic [N_OUT-1:0]      oos = '0, full = '0;
  logic [N_IN-1:0]       ack;
  logic [N_OUT-1:0]      bp;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  camp_arbiter #(.N_IN(N_IN), .N_OUT(N_OUT)) dut (
    .clk(clk), .rst_n(rst_n), .word_valid(wv), .word_kind(wk),
    .word_early(we), .word_brk(wb), .word_mask(wm), .out_oos(oos),
    .out_full(full), .ack(ack), .bp(bp));

  // bench model of the requirements
  bit               pm [N_IN];
  bit               em [N_IN];
  logic [N_OUT-1:0] rm [N_IN];
  bit               om [N_OUT];
  int               ownm [N_OUT];
  int               rrm [N_OUT];
  logic [N_IN-1:0]  gm [N_OUT];
  logic [N_IN-1:0]  m_ack;
  logic [N_OUT-1:0] m_bp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) begin pm[i] = 0; em[i] = 0; rm[i] = '0; end
      for (int o = 0; o < N_OUT; o++) begin om[o] = 0; ownm[o] = 0; rrm[o] = N_IN - 1; end
      m_ack = '0; m_bp = '0;
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        logic [N_IN-1:0] c, ce;
        int w;
        c = '0;
        for (int i = 0; i < N_IN; i++) c[i] = pm[i] & rm[i][o] & !wv[i];
        gm[o] = '0;
        w = -1;
        if (oos[o]) gm[o] = c;
        else begin
          if (om[o]) c = c & (N_IN'(1) << ownm[o]);
          ce = '0;
          for (int i = 0; i < N_IN; i++) ce[i] = c[i] & em[i];
          if (ce != '0) c = ce;
          for (int k = 1; k <= N_IN; k++) begin
            int idx;
            idx = (rrm[o] + k) % N_IN;
            if (c[idx]) begin gm[o][idx] = 1'b1; w = idx; break; end
          end
        end
        if (om[o] && wv[ownm[o]] && wk[ownm[o]] && wb[ownm[o]]) om[o] = 0;
        if (w >= 0) begin om[o] = 1; ownm[o] = w; rrm[o] = w; end
      end
      m_bp = full & ~oos;
      m_ack = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (wv[i]) begin
          if (wk[i]) begin pm[i] = 1; rm[i] = wm[i*N_OUT +: N_OUT]; em[i] = we[i]; end
          else begin pm[i] = 0; rm[i] = '0; em[i] = 0; end
        end else if (pm[i]) begin
          for (int o = 0; o < N_OUT; o++) if (gm[o][i]) rm[i][o] = 1'b0;
          if (rm[i] == '0) begin pm[i] = 0; em[i] = 0; m_ack[i] = 1'b1; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input int i, input bit kind, input logic [N_OUT-1:0] mask,
                     input bit e, input bit b);
    wv[i] = 1'b1; wk[i] = kind; we[i] = e; wb[i] = b;
    wm[i*N_OUT +: N_OUT] = mask;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(ack == m_ack, "R3 model ack", 32'(ack), 32'(m_ack));
    chk(bp == m_bp, "R11 model bp", 32'(bp), 32'(m_bp));
    wv = '0; wk = '0; we = '0; wb = '0; wm = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack == '0, "R1 ack after reset", 32'(ack), 0);
    chk(bp == '0, "R1 bp after reset", 32'(bp), 0);

    // unicast to a free output
    put(0, 1, 4'b0001, 0, 0); tick();
    chk(ack[0] == 0, "R2 no grant in word cycle", 32'(ack[0]), 0);
    tick(); chk(ack[0] == 1, "R3 ack due", 32'(ack[0]), 1);
    tick(); chk(ack[0] == 0, "R3 single pulse", 32'(ack[0]), 0);

    // multicast with one output held elsewhere
    put(1, 1, 4'b0011, 0, 0); tick(); tick();
    chk(ack[1] == 0, "R4 partial multicast", 32'(ack[1]), 0);
    tick(); chk(ack[1] == 0, "R5 still camped", 32'(ack[1]), 0);
    put(0, 1, 4'b0000, 0, 1); tick();
    chk(ack[1] == 0, "R8 released at break edge only", 32'(ack[1]), 0);
    tick(); chk(ack[1] == 1, "R8 won after break", 32'(ack[1]), 1);

    // own output requested again
    put(1, 1, 4'b0001, 0, 0); tick(); tick();
    chk(ack[1] == 1, "R9 own output", 32'(ack[1]), 1);

    // early beats ordinary
    put(2, 1, 4'b0100, 0, 0); put(3, 1, 4'b0100, 1, 0); tick(); tick();
    chk(ack[3] == 1, "R6 early wins", 32'(ack[3]), 1);
    chk(ack[2] == 0, "R6 ordinary waits", 32'(ack[2]), 0);
    put(3, 1, 4'b0000, 0, 1); tick(); tick();
    chk(ack[2] == 1, "R5 camped wins later", 32'(ack[2]), 1);

    // round robin on output 3
    put(0, 1, 4'b1000, 0, 0); put(1, 1, 4'b1000, 0, 0); tick(); tick();
    chk(ack[0] == 1 && ack[1] == 0, "R7 first after reset pointer", 32'(ack), 32'h1);
    put(0, 1, 4'b1000, 0, 1); tick(); tick();
    chk(ack[1] == 1 && ack[0] == 0, "R7 rotates past last winner", 32'(ack), 32'h2);

    // idle discards camped request
    put(0, 0, 4'b0000, 0, 0); tick();
    put(1, 1, 4'b0000, 0, 1); tick(); tick();
    chk(ack[0] == 0, "R2 idle dropped", 32'(ack[0]), 0);
    tick(); chk(ack[0] == 0, "R2 idle dropped later", 32'(ack[0]), 0);

    // replacement
    put(0, 1, 4'b0100, 0, 0); tick(); tick();
    put(0, 1, 4'b1000, 0, 0); tick(); tick();
    chk(ack[0] == 1, "R12 new request served", 32'(ack[0]), 1);
    put(2, 1, 4'b0000, 0, 1); tick(); tick();
    chk(ack[0] == 0, "R12 old request gone", 32'(ack[0]), 0);
    tick(); chk(ack[0] == 0, "R12 old request gone later", 32'(ack[0]), 0);

    // out-of-sync output
    put(3, 1, 4'b0100, 0, 0); tick(); tick();
    oos = 4'b0100;
    put(0, 1, 4'b0100, 0, 0); put(1, 1, 4'b0100, 0, 0); tick(); tick();
    chk(ack[0] == 1 && ack[1] == 1, "R10 all granted", 32'(ack), 32'h3);
    oos = '0;
    put(3, 1, 4'b0000, 0, 1); tick();
    put(2, 1, 4'b0100, 0, 0); tick(); tick();
    chk(ack[2] == 1, "R10 no owner taken", 32'(ack[2]), 1);

    // backpressure
    full = 4'b1111; oos = 4'b0100; tick();
    chk(bp == 4'b1011, "R11 bp masked by oos", 32'(bp), 32'hb);
    full = '0; oos = '0; tick();
    chk(bp == '0, "R11 bp clear", 32'(bp), 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < N_IN; i++)
        if ($urandom % 4 == 0)
          put(i, ($urandom % 4) != 0, N_OUT'($urandom), ($urandom % 8) == 0, ($urandom % 3) == 0);
      for (int o = 0; o < N_OUT; o++)
        if ($urandom % 32 == 0) oos[o] = ~oos[o];
      full = N_OUT'($urandom);
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule